// File: doc/BRIEF.md
# Lowest and Highest Set Bit Locator

This block finds one set bit in an N-bit word without a priority chain. In its default direction it takes the word, forms its two's-complement negation, and ANDs the two together. Every bit above the lowest one cancels out, so the result is a one-hot word marking the lowest set bit. For the input 101100100 the negation is 010011100 and the mask is 000000100. An OR-gate encoder then turns that one-hot word into a binary index: each index bit is the OR of every mask position whose position number has that bit set.

A direction input reuses the same datapath to find the highest set bit. The word is bit-reversed before the AND step. The resulting mask is mirrored back, so the one-hot output marks a position in the original numbering. The encoded index k is reported as N-1-k. A flag shows whether any bit was set. The block is purely combinational, and its outputs follow the inputs in the same cycle.

There is no state machine. The direction is held in a two-value enumerated type, SCAN_LOW (input 0) and SCAN_HIGH (input 1), and there are no transitions.

Top module: `edge_bit_finder`

## Requirements
- R1: With from_top = 0 and a nonzero data_in, onehot_out has exactly one bit set, at the position of the lowest set bit of data_in. Bit 0 is the least significant position.
- R2: With from_top = 0, onehot_out equals data_in ANDed with its two's-complement negation. For WIDTH = 9, the input 101100100 gives 000000100.
- R3: With from_top = 0 and a nonzero data_in, index_out is the unsigned binary position of the lowest set bit of data_in.
- R4: With from_top = 1 and a nonzero data_in, onehot_out has exactly one bit set, at the position of the highest set bit of data_in, in the original bit numbering.
- R5: With from_top = 1 and a nonzero data_in, index_out is the unsigned binary position of the highest set bit of data_in, counted from bit 0. If only bit 0 is set, it is 0.
- R6: An all-zero data_in gives onehot_out = 0, index_out = 0 and any_set = 0 in both directions.
- R7: any_set is 1 exactly when data_in is nonzero, in both directions. index_out never exceeds WIDTH-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | WIDTH | Word to search |
| from_top | input | 1 | 0 = find lowest set bit, 1 = find highest set bit |
| onehot_out | output | WIDTH | One-hot marker of the found bit, in original numbering |
| index_out | output | IDX_W | Binary position of the found bit, where IDX_W = clog2(WIDTH), at least 1 |
| any_set | output | 1 | High when data_in has at least one bit set |

## Verification
The hardest case to tell apart at the ports is the high-direction search on a word whose only set bit is bit 0. Here the inner encoder produces k = WIDTH-1, and the remap must bring it to 0. The output then matches an all-zero input in index, and only any_set and onehot_out separate the two. The stimulus sweeps all 512 words at WIDTH = 9 in both directions against a behavioural scan. Directed tasks then place single bits at each end and apply the zero word, so the remap at both extremes and the flag are each checked on their own.

// File: rtl/edge_bit_pkg.sv
package edge_bit_pkg;

    typedef enum logic {
        SCAN_LOW  = 1'b0,
        SCAN_HIGH = 1'b1
    } scan_dir_e;

    function automatic int idx_width(input int w);
        return (w > 1) ? $clog2(w) : 1;
    endfunction

endpackage

// File: rtl/bit_mirror.sv
module bit_mirror #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] din,
    input  logic             flip,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] reversed;

    for (genvar g = 0; g < WIDTH; g++) begin : g_rev
        assign reversed[g] = din[WIDTH-1-g];
    end

    assign dout = flip ? reversed : din;

endmodule

// File: rtl/lowest_one_isolator.sv
module lowest_one_isolator #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] vec,
    output logic [WIDTH-1:0] mask
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] negated;

    assign negated = (~vec) + ONE;
    assign mask    = vec & negated;

    always_comb begin
        AST_MASK_ONEHOT: assert ($onehot0(mask));                  // R1
        AST_MASK_INSIDE_INPUT: assert ((mask & ~vec) == '0);       // R2
        AST_MASK_NONZERO: assert ((vec == '0) || (mask != '0));    // R7
    end

endmodule

// File: rtl/onehot_index_encoder.sv
module onehot_index_encoder #(
    parameter int WIDTH = 16,
    parameter int IDX_W = 4
) (
    input  logic [WIDTH-1:0] onehot,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (onehot[i]) begin
                idx = idx | IDX_W'(i);
            end
        end
    end

    always_comb begin
        AST_ENC_SELECTS_SET_BIT: assert ((onehot == '0) || onehot[idx]); // R3
    end

endmodule

// File: rtl/edge_bit_finder.sv
module edge_bit_finder #(
    parameter int WIDTH = 16,
    parameter int IDX_W = edge_bit_pkg::idx_width(WIDTH)
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic             from_top,
    output logic [WIDTH-1:0] onehot_out,
    output logic [IDX_W-1:0] index_out,
    output logic             any_set
);

    import edge_bit_pkg::*;

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH - 1);

    scan_dir_e        dir;
    logic             flip;
    logic [WIDTH-1:0] oriented;
    logic [WIDTH-1:0] raw_mask;
    logic [IDX_W-1:0] raw_idx;

    assign dir  = scan_dir_e'(from_top);
    assign flip = (dir == SCAN_HIGH);

    bit_mirror #(.WIDTH(WIDTH)) u_mirror_in (
        .din  (data_in),
        .flip (flip),
        .dout (oriented)
    );

    lowest_one_isolator #(.WIDTH(WIDTH)) u_isolate (
        .vec  (oriented),
        .mask (raw_mask)
    );

    bit_mirror #(.WIDTH(WIDTH)) u_mirror_out (
        .din  (raw_mask),
        .flip (flip),
        .dout (onehot_out)
    );

    onehot_index_encoder #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_encode (
        .onehot (raw_mask),
        .idx    (raw_idx)
    );

    assign any_set = |raw_mask;

    always_comb begin
        index_out = '0;
        if (any_set) begin
            unique case (dir)
                SCAN_LOW:  index_out = raw_idx;
                SCAN_HIGH: index_out = TOP_IDX - raw_idx;
                default:   index_out = '0;
            endcase
        end
    end

    always_comb begin
        AST_ZERO_MEANS_NO_FLAG: assert ((data_in == '0) == !any_set);                  // R7
        AST_ZERO_OUTPUTS: assert (any_set || (onehot_out == '0 && index_out == '0));   // R6
        AST_INDEX_IN_RANGE: assert (index_out <= TOP_IDX);                             // R7
        AST_MARK_IS_INPUT_BIT: assert ((onehot_out & ~data_in) == '0);                 // R4
        AST_INDEX_MATCHES_MARK: assert (!any_set || onehot_out[index_out]);            // R5
    end

endmodule

// File: tb/edge_bit_finder_test.sv
module edge_bit_finder_test;

    localparam int W  = 9;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  data_in = '0;
    logic          from_top = 1'b0;
    logic [W-1:0]  onehot_out;
    logic [IW-1:0] index_out;
    logic          any_set;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    edge_bit_finder #(.WIDTH(W), .IDX_W(IW)) uut (
        .data_in    (data_in),
        .from_top   (from_top),
        .onehot_out (onehot_out),
        .index_out  (index_out),
        .any_set    (any_set)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b (in=%b top=%0d)",
                     req, what, act, exp, data_in, from_top);
        end
    endtask

    task automatic apply(input logic [W-1:0] v, input logic top);
        @(negedge clk);
        data_in  = v;
        from_top = top;
        @(posedge clk);
        #1;
    endtask

    function automatic int low_pos(input logic [W-1:0] v);
        for (int i = 0; i < W; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic int high_pos(input logic [W-1:0] v);
        for (int i = W - 1; i >= 0; i--) if (v[i]) return i;
        return -1;
    endfunction

    task automatic compare_one(input logic [W-1:0] v, input logic top);
        int p;
        logic [W-1:0] exp_oh;
        logic [W-1:0] exp_idx;
        apply(v, top);
        p = top ? high_pos(v) : low_pos(v);
        exp_oh  = (p < 0) ? '0 : (W'(1) << p);
        exp_idx = (p < 0) ? '0 : W'(p);
        if (v == '0) begin
            check("R6", "onehot zero", onehot_out, '0);
            check("R6", "index zero", W'(index_out), '0);
        end else if (!top) begin
            check("R1", "low onehot", onehot_out, exp_oh);
            check("R3", "low index", W'(index_out), exp_idx);
        end else begin
            check("R4", "high onehot", onehot_out, exp_oh);
            check("R5", "high index", W'(index_out), exp_idx);
        end
        check("R7", "any_set", W'(any_set), W'(v != '0));
    endtask

    task automatic t_reset_state;
        check("R6", "idle onehot", onehot_out, '0);
        check("R6", "idle index", W'(index_out), '0);
        check("R6", "idle flag", W'(any_set), '0);
    endtask

    task automatic t_negation_example;
        logic [W-1:0] v;
        v = 9'b101100100;
        apply(v, 1'b0);
        check("R2", "example mask", onehot_out, 9'b000000100);
        check("R2", "and-negate", onehot_out, v & (~v + W'(1)));
        check("R3", "example index", W'(index_out), W'(2));
        apply(v, 1'b1);
        check("R4", "example high mask", onehot_out, 9'b100000000);
        check("R5", "example high index", W'(index_out), W'(8));
    endtask

    task automatic t_extremes;
        apply(W'(1), 1'b1);
        check("R5", "bit0 only high index", W'(index_out), '0);
        check("R4", "bit0 only high onehot", onehot_out, W'(1));
        check("R7", "bit0 only flag", W'(any_set), W'(1));
        apply(W'(1) << (W - 1), 1'b0);
        check("R3", "top only low index", W'(index_out), W'(W - 1));
        apply('1, 1'b0);
        check("R1", "all ones low", onehot_out, W'(1));
        apply('1, 1'b1);
        check("R5", "all ones high", W'(index_out), W'(W - 1));
    endtask

    task automatic t_zero_both;
        compare_one('0, 1'b0);
        compare_one('0, 1'b1);
    endtask

    task automatic t_sweep(input logic top);
        for (int n = 0; n < (1 << W); n++) begin
            compare_one(W'(n), top);
            if (!top) check("R2", "sweep and-negate", onehot_out,
                            W'(n) & (~W'(n) + W'(1)));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        t_reset_state();
        t_negation_example();
        t_extremes();
        t_zero_both();
        t_sweep(1'b0);
        t_sweep(1'b1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule